// File: doc/BRIEF.md
# Addressed SPI Register Access Port

This block is a serial slave that lets an off-chip SPI master read and write a byte-wide register file on the chip. Each frame opens with an opcode byte that holds a fixed prefix, a 3-bit device number and a direction bit. A register address byte follows, then any number of data bytes. Up to eight instances can share one select line, because each one compares the device number in the opcode with its own 3-bit strap inputs. An instance that does not match stays silent until the frame ends.

SCK, select and MOSI are brought into the core clock domain by a synchroniser and edge-detected there. The block works in SPI mode 0 and mode 3, and tells them apart by the SCK level at the moment select becomes active. Bits travel most significant first in both directions. The register file sits outside the block: it gets a write strobe with address and data, and it returns read data for the current address.

Top module: `spireg_slave`

## Requirements
- R1: Mode 0 (SCK idle low) and mode 3 (SCK idle high) are both supported. The mode is taken from the SCK level when select goes low. MOSI is sampled on SCK rising edges, most significant bit first.
- R2: The opcode byte has bits [7:4] = 4'b0100, bits [3:1] = device number and bit 0 = direction (1 = read). If the prefix or the device number differs from `hwAddr`, the frame produces no write and MISO stays undriven.
- R3: `misoOe` is low whenever select is inactive. It is high only during the data bytes of an accepted read frame.
- R4: Read data leaves MSB first. `misoData` changes only after a detected SCK falling edge, so each bit is stable at the master's next rising edge. The first bit of a data byte is presented on the falling edge that ends the previous byte.
- R5: The second byte sets the register address, using its low `ADDR_W` bits. After every complete data byte the address increases by one, modulo 2^`ADDR_W`, for both reads and writes.
- R6: `regWrEn` pulses for exactly one clock only after the eighth bit of a write data byte. During that cycle `regAddr` and `regWrData` hold the target address and the received byte.
- R7: If select is released before a byte completes, the partial byte is discarded and produces no write.
- R8: After reset a mode-3 frame is ignored until select has been released once. Mode-0 frames are accepted at any time.
- R9: During reset `misoOe` and `regWrEn` are low and `regAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwAddr | input | 3 | Strap-set device number |
| sckIn | input | 1 | Serial clock from master |
| csNIn | input | 1 | Active-low select |
| mosiIn | input | 1 | Serial data from master |
| misoData | output | 1 | Serial data to master |
| misoOe | output | 1 | Output enable for the MISO pad driver |
| regAddr | output | ADDR_W | Register file address |
| regWrData | output | 8 | Register file write data |
| regWrEn | output | 1 | Register file write strobe |
| regRdData | input | 8 | Register file read data at `regAddr` |

## Verification
The hardest state to reach from the ports is the unarmed mode-3 condition. It exists only between reset and the first select release. So the bench starts with a mode-3 write, then applies a second reset partway through the run and sends a mode-0 write straight away. Aborted bytes come from frames cut off a few bits into a data byte. Address wrap comes from bursts that start at the top register. A behavioural register model and a queue of expected writes are compared with the strobe on every clock.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] OPC_PREFIX = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } phase_e;

  typedef struct packed {
    logic sampleBit;
    logic loadAddr;
    logic dataDone;
    logic isWrite;
    logic loadOut;
    logic shiftOut;
  } strobe_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] d;
    if (s == 0) begin : g_first
      assign d = din;
    end else begin : g_next
      assign d = g_stage[s-1].q;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= RST_VAL;
      else       q <= d;
    end
  end
  assign dout = g_stage[STAGES-1].q;
endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckS,
  input  logic              csS,
  input  logic [2:0]        hwAddr,
  input  logic [BYTE_W-1:0] rxByte,
  output strobe_t           strb,
  output logic              misoEn,
  output logic              sckFall
);
  phase_e     phase;
  logic [2:0] bitCnt;
  logic       sckPrev, csPrev, readFrame, armed;
  logic       sckRise, csStart, csStop, byteEnd, opcodeOk, live;

  assign sckRise  = sckS & ~sckPrev;
  assign sckFall  = ~sckS & sckPrev;
  assign csStart  = ~csS & csPrev;
  assign csStop   = csS & ~csPrev;
  assign byteEnd  = sckRise && (bitCnt == 3'd7);
  assign opcodeOk = (rxByte[7:4] == OPC_PREFIX) && (rxByte[3:1] == hwAddr);
  assign live     = ~csS && (phase inside {ST_OPCODE, ST_ADDR, ST_DATA});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev   <= 1'b0;
      csPrev    <= 1'b1;
      phase     <= ST_IDLE;
      bitCnt    <= '0;
      readFrame <= 1'b0;
      armed     <= 1'b0;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
      if (csStop) begin
        armed <= 1'b1;
        phase <= ST_IDLE;
      end else if (csStart) begin
        bitCnt    <= '0;
        readFrame <= 1'b0;
        phase     <= (armed || !sckS) ? ST_OPCODE : ST_SKIP;
      end else if (live && sckRise) begin
        bitCnt <= 3'(bitCnt + 3'd1);
        if (bitCnt == 3'd7) begin
          case (phase)
            ST_OPCODE: begin
              if (opcodeOk) begin
                phase     <= ST_ADDR;
                readFrame <= rxByte[0];
              end else begin
                phase <= ST_SKIP;
              end
            end
            ST_ADDR: phase <= ST_DATA;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.sampleBit = live && sckRise;
    strb.loadAddr  = live && (phase == ST_ADDR) && byteEnd;
    strb.dataDone  = live && (phase == ST_DATA) && byteEnd;
    strb.isWrite   = ~readFrame;
    strb.loadOut   = live && (phase == ST_DATA) && readFrame && sckFall && (bitCnt == 3'd0);
    strb.shiftOut  = live && (phase == ST_DATA) && readFrame && sckFall && (bitCnt != 3'd0);
  end

  assign misoEn = ~csS && (phase == ST_DATA) && readFrame;

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_SKIP) |-> (!strb.dataDone && !misoEn)) else $error("skip leak"); // R2

  AST_UNARMED_M3: assert property (@(posedge clk) disable iff (!rstN)
    (csStart && sckS && !armed) |=> (phase == ST_SKIP)) else $error("unarmed"); // R8
endmodule

// File: rtl/spireg_dp.sv
module spireg_dp
  import spireg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiS,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              misoBit
);
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] outReg;
  logic [ADDR_W-1:0] addrReg;
  logic              incPend;

  assign rxByte  = {shiftReg, mosiS};
  assign regAddr = addrReg;
  assign misoBit = outReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      outReg    <= '0;
      addrReg   <= '0;
      incPend   <= 1'b0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      incPend <= strb.dataDone;
      regWrEn <= strb.dataDone & strb.isWrite;
      if (strb.sampleBit) shiftReg <= rxByte[BYTE_W-2:0];
      if (strb.dataDone)  regWrData <= rxByte;
      if (strb.loadAddr)  addrReg <= rxByte[ADDR_W-1:0];
      else if (incPend)   addrReg <= ADDR_W'(addrReg + 1'b1);
      if (strb.loadOut)       outReg <= regRdData;
      else if (strb.shiftOut) outReg <= {outReg[BYTE_W-2:0], 1'b0};
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn) else $error("long strobe"); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == ADDR_W'($past(regAddr) + 1'b1))) else $error("no step"); // R5
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hwAddr,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  output logic              misoData,
  output logic              misoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [BYTE_W-1:0] regRdData
);
  logic [2:0]        syncOut;
  logic              sckS, csS, mosiS, sckFall;
  logic [BYTE_W-1:0] rxByte;
  strobe_t           strb;

  spireg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rstN(rstN), .din({sckIn, csNIn, mosiIn}), .dout(syncOut)
  );
  assign {sckS, csS, mosiS} = syncOut;

  spireg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(sckS), .csS(csS), .hwAddr(hwAddr),
    .rxByte(rxByte), .strb(strb), .misoEn(misoOe), .sckFall(sckFall)
  );

  spireg_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .strb(strb), .regRdData(regRdData),
    .rxByte(rxByte), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .misoBit(misoData)
  );

  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    csS |-> !misoOe) else $error("driven while idle"); // R3

  AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(misoOe) && misoOe && !$past(sckFall)) |-> $stable(misoData)) else $error("early change"); // R4

  AST_WR_NOT_READ: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !misoOe) else $error("write in read"); // R6
endmodule

// File: tb/spireg_slave_tb.sv
module spireg_slave_tb;
  localparam int AW = 5;
  localparam int NREG = 1 << AW;
  localparam int H = 8;
  localparam logic [2:0] HW = 3'b101;

  logic clk = 0, rstN = 0, sckIn = 0, csNIn = 1, mosiIn = 0;
  logic misoData, misoOe, regWrEn;
  logic [AW-1:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] mem [NREG];
  logic [7:0] model [NREG];
  logic [7:0] wrBuf [8];
  int expAddr[$], expData[$];
  int checks = 0, errors = 0, csHigh = 0;
  bit armed = 0;

  always #5 clk = ~clk;

  spireg_slave #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .hwAddr(HW), .sckIn(sckIn), .csNIn(csNIn), .mosiIn(mosiIn),
    .misoData(misoData), .misoOe(misoOe), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData)
  );
  assign regRdData = mem[regAddr];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) csHigh <= csNIn ? csHigh + 1 : 0;

  always @(negedge clk) if (rstN) begin
    if (regWrEn) begin
      if (expAddr.size() == 0) check(0, "R6", "unexpected write addr", int'(regAddr), -1);
      else begin
        check(regAddr == expAddr[0], "R6", "write address", int'(regAddr), expAddr[0]);
        check(regWrData == expData[0], "R6", "write data", int'(regWrData), expData[0]);
        void'(expAddr.pop_front());
        void'(expData.pop_front());
      end
      mem[regAddr] = regWrData;
    end
    if (csHigh >= 3) check(!misoOe, "R3", "enable while deselected", int'(misoOe), 0);
  end

  task automatic frame(input bit mode3, input logic [7:0] opc, input logic [7:0] regA,
                       input int nData, input int extraBits, input string tag);
    bit accept, isRd;
    int nBytes, oeBad, a;
    logic [7:0] txb, got;
    accept = (opc[7:4] == 4'b0100) && (opc[3:1] == HW) && (armed || !mode3);
    isRd = opc[0];
    if (accept && !isRd)
      for (int i = 0; i < nData; i++) begin
        a = (int'(regA) + i) % NREG;
        expAddr.push_back(a);
        expData.push_back(int'(wrBuf[i]));
        model[a] = wrBuf[i];
      end
    sckIn = mode3;
    repeat (H) @(negedge clk);
    csNIn = 0;
    repeat (H) @(negedge clk);
    nBytes = 2 + nData + ((extraBits > 0) ? 1 : 0);
    for (int b = 0; b < nBytes; b++) begin
      if (b == 0) txb = opc;
      else if (b == 1) txb = regA;
      else if (isRd) txb = 8'h00;
      else if (b - 2 < nData) txb = wrBuf[b-2];
      else txb = 8'hC3;
      got = 0;
      oeBad = 0;
      for (int k = 7; k >= 0; k--) begin
        if (b == nBytes - 1 && extraBits > 0 && (7 - k) >= extraBits) break;
        if (mode3) sckIn = 0;
        mosiIn = txb[k];
        repeat (H) @(negedge clk);
        if (misoOe !== (accept && isRd && b >= 2)) oeBad++;
        got[k] = misoData;
        sckIn = 1;
        repeat (H) @(negedge clk);
        if (!mode3) sckIn = 0;
      end
      check(oeBad == 0, "R3", "MISO enable pattern", oeBad, 0);
      if (accept && isRd && b >= 2 && b - 2 < nData) begin
        a = (int'(regA) + b - 2) % NREG;
        check(got == model[a], tag, "read byte", int'(got), int'(model[a]));
      end
    end
    repeat (H) @(negedge clk);
    csNIn = 1;
    repeat (4 * H) @(negedge clk);
    armed = 1;
    check(expAddr.size() == 0, tag, "writes still pending", expAddr.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] opW, opR;
    opW = {4'b0100, HW, 1'b0};
    opR = {4'b0100, HW, 1'b1};
    for (int i = 0; i < NREG; i++) begin
      mem[i] = 8'((i * 37 + 5) & 255);
      model[i] = mem[i];
    end
    repeat (5) @(negedge clk);
    check(!misoOe, "R9", "reset enable", int'(misoOe), 0);
    check(!regWrEn, "R9", "reset strobe", int'(regWrEn), 0);
    check(regAddr == 0, "R9", "reset address", int'(regAddr), 0);
    rstN = 1;
    repeat (4) @(negedge clk);

    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22;
    frame(1, opW, 8'd10, 2, 0, "R8");          // unarmed mode 3: ignored
    wrBuf[0] = 8'hA1; wrBuf[1] = 8'hB2; wrBuf[2] = 8'hC3;
    frame(0, opW, 8'd3, 3, 0, "R6");
    frame(0, opR, 8'd3, 3, 0, "R4");
    wrBuf[0] = 8'h5E; wrBuf[1] = 8'h81;
    frame(1, opW, 8'd20, 2, 0, "R1");
    frame(1, opR, 8'd9, 4, 0, "R1");           // covers 10,11 untouched (R8)
    frame(1, opR, 8'd19, 3, 0, "R1");

    wrBuf[0] = 8'hEE; wrBuf[1] = 8'hDD;
    frame(0, {4'b0100, HW ^ 3'b001, 1'b0}, 8'd3, 2, 0, "R2");
    frame(0, {4'b0110, HW, 1'b0}, 8'd4, 2, 0, "R2");
    frame(0, {4'b0100, HW ^ 3'b100, 1'b1}, 8'd3, 2, 0, "R2");
    frame(0, opR, 8'hE3, 3, 0, "R2");          // upper address bits dropped (R5)

    wrBuf[0] = 8'h5A;
    frame(0, opW, 8'd14, 1, 5, "R7");
    frame(0, opR, 8'd14, 2, 0, "R7");

    wrBuf[0] = 8'h31; wrBuf[1] = 8'h47; wrBuf[2] = 8'h6C;
    frame(0, opW, 8'd31, 3, 0, "R5");
    frame(1, opR, 8'd30, 4, 0, "R5");

    rstN = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    armed = 0;
    repeat (4) @(negedge clk);
    wrBuf[0] = 8'h99;
    frame(0, opW, 8'd7, 1, 0, "R8");           // mode 0 accepted while unarmed
    wrBuf[0] = 8'h77;
    frame(1, opW, 8'd8, 1, 0, "R8");           // now armed
    frame(1, opR, 8'd6, 4, 0, "R8");

    for (int i = 0; i < NREG; i++)
      check(mem[i] == model[i], "R6", "final register contents", int'(mem[i]), int'(model[i]));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule